// File: doc/BRIEF.md
# UART Loopback Modem Crossbar

This block sits between a UART channel's serial and modem-control logic and the chip's pins. In normal operation it passes the transmit stream and the four modem-control outputs to the pins. It synchronizes the four external modem-status inputs and reports them in a status byte. The status byte also carries change flags.

When the diagnostic loopback bit of the control register is set, the pins are cut off. The transmit stream is fed back into the receive stream. Each modem-control bit drives one of the status inputs through a fixed crossing map, so software can test the whole status path, including the change flags, without external wiring. While loopback is on, the output pins rest at their idle levels. The serializer, the deserializer and the baud generator live outside this block.

Top module: `lbx_modem_xbar`

## Requirements
- R1: `ser_rx_o` equals `ser_tx_i` while loopback is active and equals `rx_pin` otherwise.
- R2: `tx_pin` is held at 1 (mark) while loopback is active and follows `ser_tx_i` otherwise.
- R3: The control pins are active low. In normal mode `dtr_n_pin`=~mcr_bits[0], `rts_n_pin`=~mcr_bits[1], `aux1_n_pin`=~mcr_bits[2] and `aux2_n_pin`=~mcr_bits[3]. While loopback is active all four are held at 1.
- R4: In loopback the status bits are driven from the control bits, one clock edge after the control bits are sampled. The mapping is CTS (`msr_o[4]`) = mcr_bits[1], DSR (`msr_o[5]`) = mcr_bits[0], RI (`msr_o[6]`) = mcr_bits[2] and CD (`msr_o[7]`) = mcr_bits[3].
- R5: While loopback is active, the external `cts_n_pin`, `dsr_n_pin`, `dcd_n_pin` and `ri_n_pin` have no effect on `msr_o`.
- R6: Loopback is selected by mcr_bits[4] through one register. A change of that bit takes effect on the pins and on `ser_rx_o` at the first rising edge after it.
- R7: In normal mode each status bit is the inverse of its active-low pin. It passes through SYNC_STAGES synchronizer flops and then the status register, so it appears in `msr_o` after SYNC_STAGES+1 edges.
- R8: The change flags are `msr_o[0]` for CTS, `msr_o[1]` for DSR and `msr_o[3]` for CD. A flag is set by any change of the selected source, including a control write in loopback.
- R9: `msr_o[2]` is set only when the RI status falls from 1 to 0.
- R10: A cycle with `msr_rd` high clears all four flags (`msr_o[3:0]`) at the next edge. An event at that same edge sets its flag regardless.
- R11: After reset, loopback is off, `msr_o` is 0 and the synchronizers hold the inactive pin level (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcr_bits | input | 5 | Control register bits; bit 4 selects loopback |
| msr_rd | input | 1 | Status register read strobe |
| ser_tx_i | input | 1 | Serial stream from the transmitter |
| rx_pin | input | 1 | External serial input |
| cts_n_pin | input | 1 | External clear-to-send, active low |
| dsr_n_pin | input | 1 | External data-set-ready, active low |
| dcd_n_pin | input | 1 | External carrier detect, active low |
| ri_n_pin | input | 1 | External ring indicator, active low |
| tx_pin | output | 1 | External serial output |
| rts_n_pin | output | 1 | Request-to-send, active low |
| dtr_n_pin | output | 1 | Data-terminal-ready, active low |
| aux1_n_pin | output | 1 | General output 1, active low |
| aux2_n_pin | output | 1 | General output 2, active low |
| ser_rx_o | output | 1 | Serial stream to the receiver |
| msr_o | output | 8 | Status byte: [7:4] CD,RI,DSR,CTS; [3:0] dCD,falling RI,dDSR,dCTS |

## Verification
Several properties are checked on every cycle:
- the pins idle and the serial path folds back one edge after the loopback bit is seen;
- in loopback the status nibble tracks the previous cycle's control bits;
- the falling-RI flag only rises on a real fall of RI;
- a change flag only rises when its status bit actually moves;
- a read with no pending event leaves all flags clear.

Other behaviour only the bench's scenarios can show. This covers the exact synchronizer latency in normal mode and that external pin activity is ignored during loopback. It also covers the set-over-clear priority when a read meets an event, and the cycle at which a change of the loopback bit switches the receive stream.

// File: rtl/lbx_pkg.sv
package lbx_pkg;

    // modem status, active-high internal view
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_t;

    localparam int LOOP_BIT = 4;

    // external pins are active low
    function automatic mdm_t pins_to_status(input logic [3:0] pins_n);
        mdm_t s;
        s = mdm_t'(~pins_n);
        return s;
    endfunction

    // fixed crossing used in loopback: ctl[0]->DSR, ctl[1]->CTS, ctl[2]->RI, ctl[3]->CD
    function automatic mdm_t ctl_to_status(input logic [3:0] ctl);
        mdm_t s;
        s.dsr = ctl[0];
        s.cts = ctl[1];
        s.ri  = ctl[2];
        s.cd  = ctl[3];
        return s;
    endfunction

endpackage

// File: rtl/lbx_sync.sv
module lbx_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lbx_route.sv
module lbx_route
    import lbx_pkg::*;
(
    input  logic       loop_i,
    input  logic [3:0] ctl_i,
    input  logic       ser_tx_i,
    input  logic       rx_pin,
    input  logic [3:0] ext_n_i,   // {dcd_n, ri_n, dsr_n, cts_n} synchronized
    output logic       tx_pin,
    output logic       rts_n,
    output logic       dtr_n,
    output logic       aux1_n,
    output logic       aux2_n,
    output logic       ser_rx_o,
    output mdm_t       sel_o
);
    always_comb begin
        if (loop_i) begin
            tx_pin   = 1'b1;
            rts_n    = 1'b1;
            dtr_n    = 1'b1;
            aux1_n   = 1'b1;
            aux2_n   = 1'b1;
            ser_rx_o = ser_tx_i;
            sel_o    = ctl_to_status(ctl_i);
        end else begin
            tx_pin   = ser_tx_i;
            dtr_n    = ~ctl_i[0];
            rts_n    = ~ctl_i[1];
            aux1_n   = ~ctl_i[2];
            aux2_n   = ~ctl_i[3];
            ser_rx_o = rx_pin;
            sel_o    = pins_to_status(ext_n_i);
        end
    end
endmodule

// File: rtl/lbx_msr.sv
module lbx_msr
    import lbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mdm_t       sel_i,
    input  logic       rd_i,
    output logic [7:0] msr_o
);
    mdm_t       st_q;
    logic [3:0] dl_q;   // {dcd, teri, ddsr, dcts}
    logic [3:0] ev;

    always_comb begin
        ev[0] = sel_i.cts ^ st_q.cts;
        ev[1] = sel_i.dsr ^ st_q.dsr;
        ev[2] = st_q.ri & ~sel_i.ri;
        ev[3] = sel_i.cd ^ st_q.cd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            dl_q <= '0;
        end else begin
            st_q <= sel_i;
            dl_q <= (rd_i ? 4'b0 : dl_q) | ev;
        end
    end

    assign msr_o = {st_q.cd, st_q.ri, st_q.dsr, st_q.cts, dl_q};

    assert_teri_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(dl_q[2]) |-> $fell(st_q.ri));

    assert_dcts_on_change_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(dl_q[0]) |-> (st_q.cts != $past(st_q.cts)));

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_i && (sel_i == st_q)) |=> (dl_q == 4'b0));
endmodule

// File: rtl/lbx_modem_xbar.sv
module lbx_modem_xbar
    import lbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] mcr_bits,
    input  logic       msr_rd,
    input  logic       ser_tx_i,
    input  logic       rx_pin,
    input  logic       cts_n_pin,
    input  logic       dsr_n_pin,
    input  logic       dcd_n_pin,
    input  logic       ri_n_pin,
    output logic       tx_pin,
    output logic       rts_n_pin,
    output logic       dtr_n_pin,
    output logic       aux1_n_pin,
    output logic       aux2_n_pin,
    output logic       ser_rx_o,
    output logic [7:0] msr_o
);
    logic       lb_q;
    logic [3:0] ext_n_s;
    mdm_t       sel;

    always_ff @(posedge clk) begin
        if (rst) lb_q <= 1'b0;
        else     lb_q <= mcr_bits[LOOP_BIT];
    end

    lbx_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'hF)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dcd_n_pin, ri_n_pin, dsr_n_pin, cts_n_pin}),
        .q   (ext_n_s)
    );

    lbx_route u_route (
        .loop_i   (lb_q),
        .ctl_i    (mcr_bits[3:0]),
        .ser_tx_i (ser_tx_i),
        .rx_pin   (rx_pin),
        .ext_n_i  (ext_n_s),
        .tx_pin   (tx_pin),
        .rts_n    (rts_n_pin),
        .dtr_n    (dtr_n_pin),
        .aux1_n   (aux1_n_pin),
        .aux2_n   (aux2_n_pin),
        .ser_rx_o (ser_rx_o),
        .sel_o    (sel)
    );

    lbx_msr u_msr (
        .clk   (clk),
        .rst   (rst),
        .sel_i (sel),
        .rd_i  (msr_rd),
        .msr_o (msr_o)
    );

    assert_pins_idle_R2: assert property (@(posedge clk) disable iff (rst)
        mcr_bits[LOOP_BIT] |=> (tx_pin && rts_n_pin && dtr_n_pin && aux1_n_pin && aux2_n_pin));

    assert_serial_fold_R1: assert property (@(posedge clk) disable iff (rst)
        mcr_bits[LOOP_BIT] |=> (ser_rx_o == ser_tx_i));

    assert_status_map_R4: assert property (@(posedge clk) disable iff (rst)
        lb_q |=> (msr_o[4] == $past(mcr_bits[1]) && msr_o[5] == $past(mcr_bits[0]) &&
                  msr_o[6] == $past(mcr_bits[2]) && msr_o[7] == $past(mcr_bits[3])));
endmodule

// File: tb/lbx_modem_xbar_tb.sv
module lbx_modem_xbar_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] mcr_bits = '0;
    logic       msr_rd = 1'b0;
    logic       ser_tx_i = 1'b0;
    logic       rx_pin = 1'b1;
    logic       cts_n_pin = 1'b1, dsr_n_pin = 1'b1, dcd_n_pin = 1'b1, ri_n_pin = 1'b1;
    logic       tx_pin, rts_n_pin, dtr_n_pin, aux1_n_pin, aux2_n_pin, ser_rx_o;
    logic [7:0] msr_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lbx_modem_xbar #(.SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .mcr_bits(mcr_bits), .msr_rd(msr_rd),
        .ser_tx_i(ser_tx_i), .rx_pin(rx_pin),
        .cts_n_pin(cts_n_pin), .dsr_n_pin(dsr_n_pin), .dcd_n_pin(dcd_n_pin), .ri_n_pin(ri_n_pin),
        .tx_pin(tx_pin), .rts_n_pin(rts_n_pin), .dtr_n_pin(dtr_n_pin),
        .aux1_n_pin(aux1_n_pin), .aux2_n_pin(aux2_n_pin),
        .ser_rx_o(ser_rx_o), .msr_o(msr_o)
    );

    // vector: [10:6] mcr, [5] ser_tx, [4] rx, [3] cts_n, [2] dsr_n, [1] dcd_n, [0] ri_n
    localparam logic [10:0] VEC [0:7] = '{
        {5'b00000, 1'b0, 1'b1, 4'b1111},
        {5'b00101, 1'b1, 1'b0, 4'b0110},
        {5'b01010, 1'b0, 1'b1, 4'b1001},
        {5'b10000, 1'b0, 1'b1, 4'b0000},
        {5'b10001, 1'b1, 1'b0, 4'b1111},
        {5'b10110, 1'b0, 1'b1, 4'b0101},
        {5'b11111, 1'b1, 1'b0, 4'b1010},
        {5'b01111, 1'b1, 1'b1, 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected outputs from the requirements
    function automatic logic [4:0] exp_pins(input logic [10:0] v);
        logic lb;
        lb = v[10];
        if (lb) return 5'b11111;                                   // R2, R3
        return {v[5], ~v[7], ~v[6], ~v[8], ~v[9]};                 // {tx, rts_n, dtr_n, aux1_n, aux2_n}
    endfunction

    function automatic logic exp_rx(input logic [10:0] v);
        return v[10] ? v[5] : v[4];                                // R1
    endfunction

    function automatic logic [3:0] exp_st(input logic [10:0] v);    // {cd, ri, dsr, cts}
        if (v[10]) return {v[9], v[8], v[6], v[7]};                // R4
        return {~v[1], ~v[0], ~v[2], ~v[3]};                       // R7
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R11 reset state
        chk("R11 msr", msr_o, 8'h00);
        chk("R11 pins", {tx_pin, rts_n_pin, dtr_n_pin, aux1_n_pin, aux2_n_pin}, 5'b01111);
        chk("R11 rx", ser_rx_o, 1'b1);

        // table walk
        for (int i = 0; i < 8; i++) begin
            mcr_bits  = VEC[i][10:6];
            ser_tx_i  = VEC[i][5];
            rx_pin    = VEC[i][4];
            cts_n_pin = VEC[i][3];
            dsr_n_pin = VEC[i][2];
            dcd_n_pin = VEC[i][1];
            ri_n_pin  = VEC[i][0];
            cyc(5);
            chk("R2/R3 pins", {tx_pin, rts_n_pin, dtr_n_pin, aux1_n_pin, aux2_n_pin}, exp_pins(VEC[i]));
            chk("R1 rx", ser_rx_o, exp_rx(VEC[i]));
            chk("R4/R7 status", msr_o[7:4], exp_st(VEC[i]));
        end

        // R7 synchronizer latency, normal mode
        mcr_bits = 5'b00000;
        {cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin} = 4'b1111;
        cyc(5);
        msr_rd = 1'b1; cyc(1); msr_rd = 1'b0;
        chk("R10 cleared", msr_o[3:0], 4'h0);
        cts_n_pin = 1'b0;
        cyc(2);
        chk("R7 not yet", msr_o[4], 1'b0);
        cyc(1);
        chk("R7 cts seen", msr_o[4], 1'b1);
        chk("R8 dcts", msr_o[0], 1'b1);
        cts_n_pin = 1'b1;
        cyc(4);

        // R6 loopback switch timing
        ser_tx_i = 1'b0; rx_pin = 1'b1;
        mcr_bits = 5'b10000;
        #1;
        chk("R6 before edge", ser_rx_o, 1'b1);
        cyc(1);
        chk("R6 after edge", ser_rx_o, 1'b0);
        chk("R6 tx idle", tx_pin, 1'b1);
        cyc(4);
        msr_rd = 1'b1; cyc(1); msr_rd = 1'b0;
        chk("R10 clear all", msr_o[3:0], 4'h0);

        // R8 control write in loopback
        mcr_bits = 5'b10010;
        cyc(1);
        chk("R4 cts from rts", msr_o[4], 1'b1);
        chk("R8 dcts loop", msr_o[3:0], 4'b0001);
        mcr_bits = 5'b10011;
        cyc(1);
        chk("R8 ddsr loop", msr_o[3:0], 4'b0011);
        msr_rd = 1'b1; cyc(1); msr_rd = 1'b0;
        chk("R10 read clears", msr_o[3:0], 4'h0);

        // R9 falling RI only
        mcr_bits = 5'b10111;
        cyc(1);
        chk("R9 rise no flag", msr_o[3:0], 4'h0);
        chk("R4 ri", msr_o[6], 1'b1);
        mcr_bits = 5'b10011;
        cyc(1);
        chk("R9 fall flag", msr_o[3:0], 4'b0100);

        // R10 event wins over read
        msr_rd = 1'b1;
        mcr_bits = 5'b11011;
        cyc(1);
        msr_rd = 1'b0;
        chk("R10 set wins", msr_o[3:0], 4'b1000);
        msr_rd = 1'b1; cyc(1); msr_rd = 1'b0;

        // R5 external pins ignored in loopback
        {cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin} = 4'b0000;
        cyc(3);
        {cts_n_pin, dsr_n_pin, dcd_n_pin, ri_n_pin} = 4'b1010;
        cyc(5);
        chk("R5 status kept", msr_o[7:4], 4'b1011);
        chk("R5 no flags", msr_o[3:0], 4'h0);
        chk("R3 idle in loop", {rts_n_pin, dtr_n_pin, aux1_n_pin, aux2_n_pin}, 4'b1111);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule